// File: doc/BRIEF.md
# Lockable secure seconds counter

This block keeps time for a battery-backed domain. It holds a 47-bit count that goes up by one on every edge of its slow clock, nominally 32.768 kHz. The top 32 bits are whole seconds and the low 15 bits are the sub-second fraction. A single 32-bit alarm register is compared with the seconds field. On a match the block raises a sticky alarm flag.

The count stops, and keeps its value, in any of these cases:
- the enable is low;
- the surrounding status logic reports a non-valid condition;
- the unit is in its failure state, so the moment of a security event can be read back later;
- the count has run past its top and the overflow flag is set.

Software can load the seconds and fraction fields separately. Either a soft lock or a hard lock input refuses those loads. The overflow flag and the alarm flag are each cleared by writing a one to the flag's bit of a two-bit clear field.

Bus decoding, clock-domain crossing and the tamper state machine sit outside the block. Lock bits and stop conditions arrive as plain inputs.

Top module: `sec_timekeeper`

## Requirements
- R1: After reset, seconds and fraction read zero, both flags read zero, and the alarm register holds all ones (unset).
- R2: While running, the combined {seconds, fraction} value rises by exactly one per clock edge, with the fraction carrying into the seconds.
- R3: With the enable low, the non-valid input high or the failure input high, the count holds its value. It resumes once all three conditions are released.
- R4: An increment from the all-ones 47-bit value wraps the count to zero and sets the overflow flag. While the flag is set, the count holds.
- R5: A clear write with bit 0 set clears the overflow flag. Counting then resumes on the following edge.
- R6: While the soft lock or the hard lock is high, seconds and fraction writes are ignored, and counting carries on unaffected.
- R7: An accepted seconds write loads the upper 32 bits and keeps the fraction. An accepted fraction write loads the low 15 bits and keeps the seconds. No increment happens on the edge of an accepted write.
- R8: The alarm flag is set on the edge at which the seconds first become equal to the alarm register. It stays set until cleared. It is not set again while the equality merely persists.
- R9: An alarm register of all ones never sets the alarm flag, even when the seconds equal all ones.
- R10: A clear write with bit 1 set clears the alarm flag. When a new match and this clear fall on the same edge, the flag ends up set.
- R11: Alarm register writes are accepted regardless of the lock inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Time counter enable |
| nonvalid_i | input | 1 | Non-valid condition from status logic; stops counting |
| failure_i | input | 1 | Failure state from status logic; stops counting |
| lock_soft_i | input | 1 | Soft lock; refuses time writes |
| lock_hard_i | input | 1 | Hard lock; refuses time writes |
| sec_wr_i | input | 1 | Seconds write strobe |
| sec_wdata_i | input | 32 | Seconds write value |
| frac_wr_i | input | 1 | Fraction write strobe |
| frac_wdata_i | input | 15 | Fraction write value |
| alarm_wr_i | input | 1 | Alarm register write strobe |
| alarm_wdata_i | input | 32 | Alarm register write value |
| stat_clr_wr_i | input | 1 | Flag clear strobe |
| stat_clr_i | input | 2 | Clear mask: bit 0 overflow, bit 1 alarm |
| sec_o | output | 32 | Current seconds |
| frac_o | output | 15 | Current fraction |
| ovf_o | output | 1 | Overflow flag |
| alarm_o | output | 1 | Alarm flag |

## Verification
Two same-edge collisions are tested.

The first is an alarm match against an alarm clear. The counter is parked at 200 seconds with the fraction at all ones and the alarm at 201. The enable and an alarm clear are then raised together. The flag must read set after that single edge, because a new match outranks the clear.

The second is a seconds write against an increment. The write is issued while the enable is high. The loaded value must read back with no increment applied on that edge.

// File: rtl/sectk_pkg.sv
package sectk_pkg;

    // Positions inside the two-bit flag clear mask.
    localparam int CLR_W   = 2;
    localparam int CLR_OVF = 0;
    localparam int CLR_ALM = 1;

    typedef logic [CLR_W-1:0] clr_mask_t;

endpackage

// File: rtl/sectk_wr_gate.sv
module sectk_wr_gate (
    input  logic lock_soft_i,
    input  logic lock_hard_i,
    input  logic sec_wr_i,
    input  logic frac_wr_i,
    output logic sec_ld_o,
    output logic frac_ld_o
);
    logic locked;

    always_comb begin
        locked    = lock_soft_i | lock_hard_i;
        sec_ld_o  = sec_wr_i  & ~locked;
        frac_ld_o = frac_wr_i & ~locked;
    end

endmodule

// File: rtl/sectk_counter.sv
module sectk_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en_i,
    input  logic              nonvalid_i,
    input  logic              failure_i,
    input  logic              sec_ld_i,
    input  logic [SEC_W-1:0]  sec_wdata_i,
    input  logic              frac_ld_i,
    input  logic [FRAC_W-1:0] frac_wdata_i,
    input  logic              clr_ovf_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [SEC_W-1:0]  sec_next_o,
    output logic              ovf_o
);
    localparam int CNT_W = SEC_W + FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic             run;
    logic             ld_any;
    logic [CNT_W:0]   sum;

    always_comb begin
        st_d   = st_q;
        ld_any = sec_ld_i | frac_ld_i;
        run    = cnt_en_i & ~nonvalid_i & ~failure_i & ~st_q.ovf;
        sum    = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};

        if (ld_any) begin
            if (sec_ld_i) begin
                st_d.cnt[CNT_W-1:FRAC_W] = sec_wdata_i;
            end
            if (frac_ld_i) begin
                st_d.cnt[FRAC_W-1:0] = frac_wdata_i;
            end
        end else if (run) begin
            st_d.cnt = sum[CNT_W-1:0];
        end

        if (!ld_any && run && sum[CNT_W]) begin
            st_d.ovf = 1'b1;
        end else if (clr_ovf_i) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o      = st_q.cnt[CNT_W-1:FRAC_W];
    assign frac_o     = st_q.cnt[FRAC_W-1:0];
    assign sec_next_o = st_d.cnt[CNT_W-1:FRAC_W];
    assign ovf_o      = st_q.ovf;

    // R2: one step per running edge below the top value
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_any && (st_q.cnt != {CNT_W{1'b1}}))
        |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R3: stop conditions hold the count
    a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cnt_en_i || nonvalid_i || failure_i) && !ld_any) |=> $stable(st_q.cnt));

    // R4: overflow freezes the count
    a_r4_ovf_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ld_any) |=> $stable(st_q.cnt));

    // R4: overflow appears together with a wrapped count
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> (st_q.cnt == '0));

endmodule

// File: rtl/sectk_alarm.sv
module sectk_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alm_wr_i,
    input  logic [SEC_W-1:0] alm_wdata_i,
    input  logic             clr_alm_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [SEC_W-1:0] sec_next_i,
    output logic             flag_o
);
    typedef struct packed {
        logic [SEC_W-1:0] val;
        logic             flag;
    } alm_state_t;

    alm_state_t st_d, st_q;
    logic       match_now;
    logic       match_next;
    logic       hit;

    always_comb begin
        st_d = st_q;
        if (alm_wr_i) begin
            st_d.val = alm_wdata_i;
        end

        match_now  = (sec_i == st_q.val);
        match_next = (sec_next_i == st_d.val) && (st_d.val != {SEC_W{1'b1}});
        hit        = match_next & ~match_now;

        if (hit) begin
            st_d.flag = 1'b1;
        end else if (clr_alm_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val  <= {SEC_W{1'b1}};
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R8: flag stays set until a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_alm_i) |=> st_q.flag);

    // R8: a new flag coincides with seconds equal to the alarm register
    a_r8_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> (sec_i == st_q.val));

    // R9: an unset alarm never raises the flag
    a_r9_unset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.val == {SEC_W{1'b1}}) && !alm_wr_i && !st_q.flag) |=> !st_q.flag);

endmodule

// File: rtl/sec_timekeeper.sv
module sec_timekeeper #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cnt_en_i,
    input  logic                      nonvalid_i,
    input  logic                      failure_i,
    input  logic                      lock_soft_i,
    input  logic                      lock_hard_i,
    input  logic                      sec_wr_i,
    input  logic [SEC_W-1:0]          sec_wdata_i,
    input  logic                      frac_wr_i,
    input  logic [FRAC_W-1:0]         frac_wdata_i,
    input  logic                      alarm_wr_i,
    input  logic [SEC_W-1:0]          alarm_wdata_i,
    input  logic                      stat_clr_wr_i,
    input  logic [sectk_pkg::CLR_W-1:0] stat_clr_i,
    output logic [SEC_W-1:0]          sec_o,
    output logic [FRAC_W-1:0]         frac_o,
    output logic                      ovf_o,
    output logic                      alarm_o
);
    import sectk_pkg::*;

    logic             sec_ld;
    logic             frac_ld;
    logic             clr_ovf;
    logic             clr_alm;
    logic [SEC_W-1:0] sec_next;

    always_comb begin
        clr_ovf = stat_clr_wr_i & stat_clr_i[CLR_OVF];
        clr_alm = stat_clr_wr_i & stat_clr_i[CLR_ALM];
    end

    sectk_wr_gate u_gate (
        .lock_soft_i (lock_soft_i),
        .lock_hard_i (lock_hard_i),
        .sec_wr_i    (sec_wr_i),
        .frac_wr_i   (frac_wr_i),
        .sec_ld_o    (sec_ld),
        .frac_ld_o   (frac_ld)
    );

    sectk_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_en_i     (cnt_en_i),
        .nonvalid_i   (nonvalid_i),
        .failure_i    (failure_i),
        .sec_ld_i     (sec_ld),
        .sec_wdata_i  (sec_wdata_i),
        .frac_ld_i    (frac_ld),
        .frac_wdata_i (frac_wdata_i),
        .clr_ovf_i    (clr_ovf),
        .sec_o        (sec_o),
        .frac_o       (frac_o),
        .sec_next_o   (sec_next),
        .ovf_o        (ovf_o)
    );

    sectk_alarm #(.SEC_W(SEC_W)) u_alm (
        .clk         (clk),
        .rst_n       (rst_n),
        .alm_wr_i    (alarm_wr_i),
        .alm_wdata_i (alarm_wdata_i),
        .clr_alm_i   (clr_alm),
        .sec_i       (sec_o),
        .sec_next_i  (sec_next),
        .flag_o      (alarm_o)
    );

    // R6: a locked, idle counter cannot be moved by any time write
    a_r6_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_soft_i || lock_hard_i) && !cnt_en_i) |=> ($stable(sec_o) && $stable(frac_o)));

    // R5: a clear strobe on bit 0 leaves overflow low after the edge
    a_r5_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && ovf_o) |=> !ovf_o);

endmodule

// File: tb/sec_timekeeper_tb_top.sv
`timescale 1ns/1ps
module sec_timekeeper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, nonvalid = 1'b0, failure = 1'b0;
    logic        lock_soft = 1'b0, lock_hard = 1'b0;
    logic        sec_wr = 1'b0, frac_wr = 1'b0, alarm_wr = 1'b0, clr_wr = 1'b0;
    logic [31:0] sec_wdata = '0, alarm_wdata = '0;
    logic [14:0] frac_wdata = '0;
    logic [1:0]  clr_mask = '0;
    logic [31:0] sec;
    logic [14:0] frac;
    logic        ovf, alarm;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sec_timekeeper dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_en_i      (cnt_en),
        .nonvalid_i    (nonvalid),
        .failure_i     (failure),
        .lock_soft_i   (lock_soft),
        .lock_hard_i   (lock_hard),
        .sec_wr_i      (sec_wr),
        .sec_wdata_i   (sec_wdata),
        .frac_wr_i     (frac_wr),
        .frac_wdata_i  (frac_wdata),
        .alarm_wr_i    (alarm_wr),
        .alarm_wdata_i (alarm_wdata),
        .stat_clr_wr_i (clr_wr),
        .stat_clr_i    (clr_mask),
        .sec_o         (sec),
        .frac_o        (frac),
        .ovf_o         (ovf),
        .alarm_o       (alarm)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
            bad = bad + 1;
            total = total + 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_time(input logic ws, input logic [31:0] s, input logic wf, input logic [14:0] f);
        sec_wr = ws; sec_wdata = s; frac_wr = wf; frac_wdata = f;
        @(negedge clk);
        sec_wr = 1'b0; frac_wr = 1'b0;
    endtask

    task automatic wr_alarm(input logic [31:0] a);
        alarm_wr = 1'b1; alarm_wdata = a;
        @(negedge clk);
        alarm_wr = 1'b0;
    endtask

    task automatic clr(input logic [1:0] m);
        clr_wr = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    typedef struct packed {
        logic [31:0] s;
        logic [14:0] f;
        logic [7:0]  n;
        logic [31:0] es;
        logic [14:0] ef;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{s: 32'h0000_0000, f: 15'h0000, n: 8'd3,  es: 32'h0000_0000, ef: 15'h0003},
        '{s: 32'h0000_0005, f: 15'h7FFD, n: 8'd4,  es: 32'h0000_0006, ef: 15'h0001},
        '{s: 32'h1234_5678, f: 15'h7FFF, n: 8'd1,  es: 32'h1234_5679, ef: 15'h0000},
        '{s: 32'hABCD_0000, f: 15'h0100, n: 8'd16, es: 32'hABCD_0000, ef: 15'h0110}
    };

    initial begin
        cyc(3);
        chk("R1 sec reset", 64'(sec), 64'h0);
        chk("R1 frac reset", 64'(frac), 64'h0);
        chk("R1 ovf reset", 64'(ovf), 64'h0);
        chk("R1 alarm reset", 64'(alarm), 64'h0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 idle after reset", 64'({sec, frac}), 64'h0);

        // R2 / R7: vector table walk
        for (int i = 0; i < 4; i++) begin
            wr_time(1'b1, VECS[i].s, 1'b1, VECS[i].f);
            cnt_en = 1'b1;
            repeat (int'(VECS[i].n)) @(posedge clk);
            @(negedge clk);
            cnt_en = 1'b0;
            chk("R2 table sec", 64'(sec), 64'(VECS[i].es));
            chk("R2 table frac", 64'(frac), 64'(VECS[i].ef));
        end

        // R7: partial writes
        wr_time(1'b0, 32'h0, 1'b1, 15'h0055);
        chk("R7 frac write keeps sec", 64'({sec, frac}), 64'({32'hABCD_0000, 15'h0055}));
        wr_time(1'b1, 32'h0000_0042, 1'b0, 15'h0);
        chk("R7 sec write keeps frac", 64'({sec, frac}), 64'({32'h0000_0042, 15'h0055}));
        cnt_en = 1'b1;
        wr_time(1'b1, 32'h0000_0050, 1'b0, 15'h0);
        cnt_en = 1'b0;
        chk("R7 write edge no increment", 64'({sec, frac}), 64'({32'h0000_0050, 15'h0055}));

        // R3: stop conditions
        cnt_en = 1'b1; nonvalid = 1'b1;
        cyc(5);
        chk("R3 nonvalid holds", 64'({sec, frac}), 64'({32'h50, 15'h55}));
        nonvalid = 1'b0; failure = 1'b1;
        cyc(5);
        chk("R3 failure holds", 64'({sec, frac}), 64'({32'h50, 15'h55}));
        failure = 1'b0; cnt_en = 1'b0;
        cyc(5);
        chk("R3 disable holds", 64'({sec, frac}), 64'({32'h50, 15'h55}));
        cnt_en = 1'b1;
        cyc(2);
        cnt_en = 1'b0;
        chk("R3 resumes", 64'({sec, frac}), 64'({32'h50, 15'h57}));

        // R6: locks
        lock_soft = 1'b1;
        wr_time(1'b1, 32'h999, 1'b1, 15'h111);
        chk("R6 soft lock refuses", 64'({sec, frac}), 64'({32'h50, 15'h57}));
        lock_soft = 1'b0; lock_hard = 1'b1;
        wr_time(1'b1, 32'h999, 1'b1, 15'h111);
        chk("R6 hard lock refuses", 64'({sec, frac}), 64'({32'h50, 15'h57}));
        cnt_en = 1'b1;
        sec_wr = 1'b1; sec_wdata = 32'h777;
        cyc(3);
        sec_wr = 1'b0; cnt_en = 1'b0;
        chk("R6 locked write leaves counting", 64'({sec, frac}), 64'({32'h50, 15'h5A}));
        lock_hard = 1'b0;

        // R9 / R4 / R5: top of range
        wr_time(1'b1, 32'hFFFF_FFFF, 1'b1, 15'h7FFE);
        chk("R9 unset alarm ignores all-ones seconds", 64'(alarm), 64'h0);
        cnt_en = 1'b1;
        cyc(1);
        chk("R4 last step", 64'({ovf, frac}), 64'({1'b0, 15'h7FFF}));
        cyc(1);
        chk("R4 wrap to zero", 64'({sec, frac}), 64'h0);
        chk("R4 ovf set", 64'(ovf), 64'h1);
        cyc(4);
        chk("R4 frozen while ovf", 64'({ovf, sec, frac}), 64'({1'b1, 47'h0}));
        chk("R9 still no alarm", 64'(alarm), 64'h0);
        clr(2'b01);
        chk("R5 ovf cleared", 64'({ovf, sec, frac}), 64'h0);
        cyc(1);
        chk("R5 counting resumes", 64'({sec, frac}), 64'h1);
        cnt_en = 1'b0;

        // R8: alarm match and stickiness
        wr_time(1'b1, 32'd100, 1'b1, 15'h7FFE);
        wr_alarm(32'd101);
        chk("R8 no early alarm", 64'(alarm), 64'h0);
        cnt_en = 1'b1;
        cyc(1);
        chk("R8 not yet at alarm", 64'(alarm), 64'h0);
        cyc(1);
        cnt_en = 1'b0;
        chk("R8 sec at alarm", 64'(sec), 64'd101);
        chk("R8 alarm set on match edge", 64'(alarm), 64'h1);
        cyc(3);
        chk("R8 alarm sticky", 64'(alarm), 64'h1);
        clr(2'b10);
        chk("R10 alarm cleared", 64'(alarm), 64'h0);
        cyc(3);
        chk("R8 persisting match no re-set", 64'(alarm), 64'h0);

        // R10: match and clear on the same edge
        wr_time(1'b1, 32'd200, 1'b1, 15'h7FFF);
        wr_alarm(32'd201);
        cnt_en = 1'b1; clr_wr = 1'b1; clr_mask = 2'b10;
        @(negedge clk);
        cnt_en = 1'b0; clr_wr = 1'b0; clr_mask = 2'b00;
        chk("R10 sec reached alarm", 64'(sec), 64'd201);
        chk("R10 set wins over clear", 64'(alarm), 64'h1);
        clr(2'b10);
        chk("R10 plain clear", 64'(alarm), 64'h0);

        // R11: alarm writes under lock
        lock_hard = 1'b1; lock_soft = 1'b1;
        wr_alarm(32'h300);
        chk("R11 no alarm for other value", 64'(alarm), 64'h0);
        wr_alarm(32'd201);
        chk("R11 alarm write accepted under lock", 64'(alarm), 64'h1);
        chk("R11 seconds untouched", 64'(sec), 64'd201);
        lock_hard = 1'b0; lock_soft = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule